// File: doc/BRIEF.md
# Priority interrupt request arbiter

The arbiter gathers interrupt requests from a set of device slots. Each slot has a request input and a static three-bit urgency setting, from 0 (least urgent) to 7 (most urgent). Every cycle the block registers the most urgent pending request. Its slot index and level go to the processor. The block raises an interrupt only when that level is strictly above the processor's running priority level, so a device can never preempt a program of equal or greater urgency.

The processor looks at the interrupt line at one point only: the instruction boundary after the store phase and before the next fetch. The block therefore gates the line with a boundary strobe. The interrupt line and the acknowledge act as a valid/ready pair. A transfer takes place on a clock edge where both are high. On that edge the block latches the winning index and level into a taken record and pulses a strobe for one cycle. While the acknowledge is low the offer is not held. The valid side follows the live requests and may drop or change, and nothing is latched.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, irq_out, take_stb, win_idx, win_level, take_idx and take_level are all zero.
- R2: Among slots with dev_req high, the one whose level field (bits 3i+2..3i of dev_level for slot i) is largest is reported on win_idx and win_level.
- R3: When several requesting slots share the largest level, the lowest-numbered slot wins.
- R4: irq_out is high only if win_level is strictly greater than cpu_level; an equal level does not interrupt.
- R5: irq_out is low whenever insn_boundary is low, and insn_boundary and cpu_level act on irq_out in the same cycle.
- R6: With no request registered, irq_out is low and win_idx and win_level are driven to zero.
- R7: A clock edge with irq_out and irq_ack both high copies win_idx and win_level into take_idx and take_level, and take_stb is high for exactly the following cycle.
- R8: irq_ack on an edge where irq_out is low has no effect: take_stb stays low and take_idx and take_level keep their values.
- R9: The level field of a slot whose request is low does not affect the winner.
- R10: win_idx and win_level reflect dev_req and dev_level as sampled at the previous clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_DEV | Request per slot |
| dev_level | input | 3*N_DEV | Urgency per slot, slot i at bits 3i+2..3i |
| cpu_level | input | 3 | Running processor priority level |
| insn_boundary | input | 1 | High at the instruction boundary |
| irq_ack | input | 1 | Processor accepts the offered interrupt (ready) |
| irq_out | output | 1 | Interrupt offered to the processor (valid) |
| win_idx | output | IDX_W | Winning slot index |
| win_level | output | 3 | Winning slot level |
| take_stb | output | 1 | One-cycle pulse after an accepted interrupt |
| take_idx | output | IDX_W | Slot index latched at acceptance |
| take_level | output | 3 | Level latched at acceptance |

## Verification
The properties treat dev_level as static while a slot requests. They also assume cpu_level and insn_boundary are ordinary synchronous inputs whose effect on irq_out is immediate. The stimulus changes every input only on the falling clock edge. It changes level settings only while the slots concerned are idle or are being set up for a new scenario. Under these conditions the capture and gating properties compare well-defined values at each rising edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_lvl_encoder.sv
module irq_lvl_encoder
  import irq_arb_pkg::*;
#(
  parameter int N_DEV = 8,
  parameter int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [N_DEV-1:0]       req,
  input  logic [N_DEV*LVL_W-1:0] levels,
  output logic                   found,
  output logic [IDX_W-1:0]       best_idx,
  output lvl_t                   best_lvl
);
  lvl_t lvl_a [N_DEV];

  for (genvar g = 0; g < N_DEV; g++) begin : g_split
    assign lvl_a[g] = levels[g*LVL_W +: LVL_W];
  end

  // Strictly-greater update keeps the lowest index on a tie.
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (req[i] && (!found || lvl_a[i] > best_lvl)) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
(
  input  logic pend_vld,
  input  lvl_t pend_lvl,
  input  lvl_t cpu_level,
  input  logic boundary,
  output logic irq
);
  assign irq = boundary && pend_vld && (pend_lvl > cpu_level);
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] idx_in,
  input  lvl_t             lvl_in,
  output logic             stb,
  output logic [IDX_W-1:0] idx_q,
  output lvl_t             lvl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb   <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else begin
      stb <= fire;
      if (fire) begin
        idx_q <= idx_in;
        lvl_q <= lvl_in;
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int N_DEV = 8,
  parameter int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       dev_req,
  input  logic [N_DEV*LVL_W-1:0] dev_level,
  input  logic [LVL_W-1:0]       cpu_level,
  input  logic                   insn_boundary,
  input  logic                   irq_ack,
  output logic                   irq_out,
  output logic [IDX_W-1:0]       win_idx,
  output logic [LVL_W-1:0]       win_level,
  output logic                   take_stb,
  output logic [IDX_W-1:0]       take_idx,
  output logic [LVL_W-1:0]       take_level
);
  logic             enc_found;
  logic [IDX_W-1:0] enc_idx;
  lvl_t             enc_lvl;
  logic             pend_vld;
  logic [IDX_W-1:0] pend_idx;
  lvl_t             pend_lvl;
  lvl_t             cap_lvl;

  irq_lvl_encoder #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_enc (
    .req      (dev_req),
    .levels   (dev_level),
    .found    (enc_found),
    .best_idx (enc_idx),
    .best_lvl (enc_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_idx <= '0;
      pend_lvl <= '0;
    end else begin
      pend_vld <= enc_found;
      pend_idx <= enc_found ? enc_idx : '0;
      pend_lvl <= enc_found ? enc_lvl : '0;
    end
  end

  irq_gate u_gate (
    .pend_vld  (pend_vld),
    .pend_lvl  (pend_lvl),
    .cpu_level (cpu_level),
    .boundary  (insn_boundary),
    .irq       (irq_out)
  );

  irq_capture #(.IDX_W(IDX_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (irq_out && irq_ack),
    .idx_in (pend_idx),
    .lvl_in (pend_lvl),
    .stb    (take_stb),
    .idx_q  (take_idx),
    .lvl_q  (cap_lvl)
  );

  assign win_idx    = pend_idx;
  assign win_level  = pend_lvl;
  assign take_level = cap_lvl;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int N_DEV = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DEV-1:0] dev_req,
  input logic [2:0]       cpu_level,
  input logic             insn_boundary,
  input logic             irq_ack,
  input logic             irq_out,
  input logic [IDX_W-1:0] win_idx,
  input logic [2:0]       win_level,
  input logic             take_stb,
  input logic [IDX_W-1:0] take_idx,
  input logic [2:0]       take_level
);
  assert_above_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_level > cpu_level));

  assert_boundary_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> insn_boundary);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req == '0) |=> (!irq_out && win_idx == '0 && win_level == '0));

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && irq_ack) |=> (take_stb && take_idx == $past(win_idx)
                              && take_level == $past(win_level)));

  assert_no_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_out && irq_ack) |=> (!take_stb && $stable(take_idx) && $stable(take_level)));
endmodule

bind irq_prio_arb irq_arb_chk #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dev_req       (dev_req),
  .cpu_level     (cpu_level),
  .insn_boundary (insn_boundary),
  .irq_ack       (irq_ack),
  .irq_out       (irq_out),
  .win_idx       (win_idx),
  .win_level     (win_level),
  .take_stb      (take_stb),
  .take_idx      (take_idx),
  .take_level    (take_level)
);

// File: tb/test_irq_prio_arb.sv
`timescale 1ns/1ps
module test_irq_prio_arb;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_req = '0;
  logic [N*3-1:0] dev_level = '0;
  logic [2:0]    cpu_level = '0;
  logic          insn_boundary = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_out;
  logic [IW-1:0] win_idx;
  logic [2:0]    win_level;
  logic          take_stb;
  logic [IW-1:0] take_idx;
  logic [2:0]    take_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_arb #(.N_DEV(N)) i_irq_prio_arb (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_level(dev_level),
    .cpu_level(cpu_level), .insn_boundary(insn_boundary), .irq_ack(irq_ack),
    .irq_out(irq_out), .win_idx(win_idx), .win_level(win_level),
    .take_stb(take_stb), .take_idx(take_idx), .take_level(take_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_lvl(input int slot, input int lvl);
    dev_level[slot*3 +: 3] = 3'(lvl);
  endtask

  // Wait one rising edge, then sample mid-low phase.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk);
    dev_req = '0; dev_level = '0; irq_ack = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 irq_out", irq_out, 0);
    chk("R1 take_stb", take_stb, 0);
    chk("R1 win_idx", win_idx, 0);
    chk("R1 win_level", win_level, 0);
    chk("R1 take_idx", take_idx, 0);
    chk("R1 take_level", take_level, 0);
  endtask

  task automatic t_single();
    @(negedge clk);
    set_lvl(3, 5); dev_req = 8'b0000_1000; cpu_level = 3'd2; insn_boundary = 1'b1;
    #1;
    chk("R10 win_idx before edge", win_idx, 0);
    chk("R10 irq before edge", irq_out, 0);
    @(negedge clk); #1;
    chk("R2 single win_idx", win_idx, 3);
    chk("R2 single win_level", win_level, 5);
    chk("R2 single irq", irq_out, 1);
    clear_all();
  endtask

  task automatic t_multi();
    @(negedge clk);
    set_lvl(1, 2); set_lvl(4, 6); set_lvl(6, 4);
    dev_req = 8'b0101_0010; cpu_level = 3'd0;
    step();
    chk("R2 multi win_idx", win_idx, 4);
    chk("R2 multi win_level", win_level, 6);
    clear_all();
  endtask

  task automatic t_tie();
    @(negedge clk);
    set_lvl(2, 5); set_lvl(5, 5); set_lvl(7, 3);
    dev_req = 8'b1010_0100;
    step();
    chk("R3 tie win_idx", win_idx, 2);
    chk("R3 tie win_level", win_level, 5);
    clear_all();
  endtask

  task automatic t_compare();
    @(negedge clk);
    set_lvl(0, 4); dev_req = 8'b0000_0001; cpu_level = 3'd4;
    step();
    chk("R4 equal level irq", irq_out, 0);
    cpu_level = 3'd3; #1;
    chk("R4 higher level irq", irq_out, 1);
    cpu_level = 3'd7; #1;
    chk("R4 lower level irq", irq_out, 0);
    cpu_level = 3'd0;
    clear_all();
  endtask

  task automatic t_boundary();
    @(negedge clk);
    set_lvl(5, 7); dev_req = 8'b0010_0000; insn_boundary = 1'b0;
    step();
    chk("R5 boundary low irq", irq_out, 0);
    chk("R5 win_idx still shown", win_idx, 5);
    insn_boundary = 1'b1; #1;
    chk("R5 boundary high irq", irq_out, 1);
    clear_all();
  endtask

  task automatic t_idle();
    @(negedge clk);
    set_lvl(7, 7); set_lvl(1, 1); dev_req = 8'b0000_0010; cpu_level = 3'd0;
    step();
    chk("R9 idle slot ignored idx", win_idx, 1);
    chk("R9 idle slot ignored level", win_level, 1);
    dev_req = '0;
    step();
    chk("R6 no request irq", irq_out, 0);
    chk("R6 no request idx", win_idx, 0);
    chk("R6 no request level", win_level, 0);
    clear_all();
  endtask

  task automatic t_capture();
    @(negedge clk);
    set_lvl(6, 6); dev_req = 8'b0100_0000; cpu_level = 3'd0; insn_boundary = 1'b1;
    step();
    chk("R7 irq offered", irq_out, 1);
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R7 take_stb", take_stb, 1);
    chk("R7 take_idx", take_idx, 6);
    chk("R7 take_level", take_level, 6);
    step();
    chk("R7 take_stb one cycle", take_stb, 0);
    chk("R7 take_idx held", take_idx, 6);
    clear_all();
  endtask

  task automatic t_stray_ack();
    @(negedge clk);
    set_lvl(2, 3); dev_req = 8'b0000_0100; insn_boundary = 1'b0; irq_ack = 1'b1;
    step();
    step();
    chk("R8 stray ack take_stb", take_stb, 0);
    chk("R8 stray ack take_idx", take_idx, 6);
    chk("R8 stray ack take_level", take_level, 6);
    irq_ack = 1'b0;
    clear_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_single();
    t_multi();
    t_tie();
    t_compare();
    t_boundary();
    t_idle();
    t_capture();
    t_stray_ack();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule